// File: doc/BRIEF.md
# YCbCr 4:2:2 to 4:4:4 Input Formatter

This block sits at the pixel entry of a video encoder. It receives 4:2:2 YCbCr samples on a 16-bit port clocked by the 2x pixel clock and turns them into one luma/blue-difference/red-difference triple per pixel, marked by a one-cycle valid strobe. Each pair of luma samples shares one Cb/Cr pair: the first pixel of the pair is emitted once its Cr arrives, the second reuses the held chroma.

Two multiplexing modes are chosen at run time. In the wide mode each word carries luma in the upper byte and alternating chroma in the lower byte, and words are taken only on every other clock edge, gated by an internally generated half-rate clock. In the narrow mode a single byte stream on the upper byte carries chroma and luma interleaved, one byte per edge. A blanking input that is high during inactive video restarts the component order so every active line begins on a Cb sample. Luma below black level is raised to black; chroma passes untouched.

Top module: `p422_formatter`

## Requirements
- R1: While reset is applied, `y_out`, `cb_out` and `cr_out` are 0, `valid_out` is 0 and `half_clk` is 0.
- R2: After reset, `half_clk` inverts on every rising edge of `clk2`, its first value being 0.
- R3: Emitted luma below 16 becomes 16; every luma value from 16 to 255, including values above 235, is emitted unchanged.
- R4: Emitted Cb and Cr equal the input chroma bytes for all values 0 to 255.
- R5: With `wide_mode`=0 one byte is taken from `pix_in[15:8]` on every `clk2` edge in the order Cb, Y0, Cr, Y1; `pix_in[7:0]` is ignored. Right after the Cr edge `valid_out` is 1 with (Y0, Cb, Cr), right after the Y1 edge it is 1 with (Y1, Cb, Cr), and after the Cb and Y0 edges it is 0.
- R6: With `wide_mode`=1 a word is taken only on edges where `half_clk` is 0 just before the edge; `pix_in[15:8]` is luma and `pix_in[7:0]` is chroma, Cb in the first word of a pair and Cr in the second. Right after the second word's edge `valid_out` is 1 with (Y0, Cb, Cr); right after the following edge it is 1 with (Y1, Cb, Cr).
- R7: With `wide_mode`=1, `pix_in` and `blank_in` at edges where `half_clk` is 1 have no effect on any output.
- R8: A sample edge with `blank_in`=1 produces no pixel and returns the component order to its start, so the next active sample is treated as Cb (and Y0) even if the previous line stopped mid-group; `valid_out` is 0 after that edge and after the one following it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2 | input | 1 | 2x pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1: 16-bit words; 0: byte stream on upper byte |
| blank_in | input | 1 | 1 during inactive video |
| pix_in | input | 16 | Pixel data |
| half_clk | output | 1 | Half-rate pixel clock, low out of reset |
| valid_out | output | 1 | One-cycle strobe per emitted pixel |
| y_out | output | 8 | Luma, floor-clamped |
| cb_out | output | 8 | Blue-difference chroma |
| cr_out | output | 8 | Red-difference chroma |

## Verification
The narrow mode is driven with every luma value in both positions of a pair while Cb and Cr follow unrelated ramps, so a swapped luma slot, a chroma taken from the wrong byte or a clamp at the wrong threshold all show up as mismatches; the lower byte carries junk that must not leak. The wide mode sweeps all luma values with junk data and a raised blanking input on the off-phase edges, separating correct half-rate gating from sampling on every edge. Both modes are also fed a line that stops mid-group followed by a blanking gap, which distinguishes a design that restarts on Cb from one that carries its phase across lines.

// File: rtl/p422_pkg.sv
package p422_pkg;
  localparam int CW      = 8;
  localparam int Y_FLOOR = 16;

  typedef logic [1:0] phase_t;

  function automatic logic [CW-1:0] floor_clamp(input logic [CW-1:0] v,
                                                input logic [CW-1:0] f);
    floor_clamp = (v < f) ? f : v;
  endfunction
endpackage

// File: rtl/p422_rst_sync.sv
module p422_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/p422_half_gen.sv
module p422_half_gen (
  input  logic clk,
  input  logic rst_n,
  output logic half
);
  logic half_q;
  logic half_d;

  always_comb half_d = ~half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_d;
  end

  assign half = half_q;

  // R2
  half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (half_q != $past(half_q)));
endmodule

// File: rtl/p422_unpack.sv
module p422_unpack
  import p422_pkg::*;
#(
  parameter int W = CW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wide,
  input  logic         half,
  input  logic         blank,
  input  logic [2*W-1:0] pix,
  output logic         emit_v,
  output logic [W-1:0] emit_y,
  output logic [W-1:0] emit_cb,
  output logic [W-1:0] emit_cr
);
  localparam int PW = 2 * W;

  logic [W-1:0] hi_byte, lo_byte;
  logic         take;

  phase_t       phase_q, phase_d;
  logic [W-1:0] cb_q, cb_d;
  logic [W-1:0] cr_q, cr_d;
  logic [W-1:0] y0_q, y0_d;
  logic [W-1:0] y1_q, y1_d;
  logic         pend_q, pend_d;

  assign hi_byte = pix[PW-1:W];
  assign lo_byte = pix[W-1:0];
  assign take    = wide ? ~half : 1'b1;

  always_comb begin
    phase_d = phase_q;
    cb_d    = cb_q;
    cr_d    = cr_q;
    y0_d    = y0_q;
    y1_d    = y1_q;
    pend_d  = pend_q;
    emit_v  = 1'b0;
    emit_y  = y0_q;
    emit_cb = cb_q;
    emit_cr = cr_q;
    if (take) begin
      if (blank) begin
        phase_d = '0;
        pend_d  = 1'b0;
      end else if (!wide) begin
        phase_d = phase_q + 2'd1;
        case (phase_q)
          2'd0: cb_d = hi_byte;
          2'd1: y0_d = hi_byte;
          2'd2: begin
            cr_d    = hi_byte;
            emit_v  = 1'b1;
            emit_y  = y0_q;
            emit_cr = hi_byte;
          end
          default: begin
            emit_v = 1'b1;
            emit_y = hi_byte;
          end
        endcase
      end else if (!phase_q[0]) begin
        cb_d    = lo_byte;
        y0_d    = hi_byte;
        phase_d = 2'd1;
        pend_d  = 1'b0;
      end else begin
        cr_d    = lo_byte;
        y1_d    = hi_byte;
        emit_v  = 1'b1;
        emit_y  = y0_q;
        emit_cr = lo_byte;
        pend_d  = 1'b1;
        phase_d = 2'd0;
      end
    end else if (pend_q) begin
      emit_v = 1'b1;
      emit_y = y1_q;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      cb_q    <= '0;
      cr_q    <= '0;
      y0_q    <= '0;
      y1_q    <= '0;
      pend_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pend_q  <= pend_d;
      if (take) begin
        cb_q <= cb_d;
        cr_q <= cr_d;
        y0_q <= y0_d;
        y1_q <= y1_d;
      end
    end
  end

  // R8
  blank_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && blank) |=> !emit_v);

  // R6
  second_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && take && !blank && phase_q[0]) |=> (emit_v || !wide));

  // R5
  narrow_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && !blank && phase_q == 2'd1) |=> (emit_v || wide || blank));
endmodule

// File: rtl/p422_outreg.sv
module p422_outreg
  import p422_pkg::*;
#(
  parameter int W        = CW,
  parameter int FLOOR    = Y_FLOOR,
  parameter bit CLAMP_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_v,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] in_cb,
  input  logic [W-1:0] in_cr,
  output logic         out_v,
  output logic [W-1:0] out_y,
  output logic [W-1:0] out_cb,
  output logic [W-1:0] out_cr
);
  localparam logic [W-1:0] FLOOR_V = W'(FLOOR);

  logic [W-1:0] y_lim;
  logic         v_q;
  logic [W-1:0] y_q, cb_q, cr_q;

  generate
    if (CLAMP_EN) begin : g_clamp
      always_comb y_lim = floor_clamp(in_y, FLOOR_V);
    end else begin : g_raw
      always_comb y_lim = in_y;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      y_q  <= '0;
      cb_q <= '0;
      cr_q <= '0;
    end else begin
      v_q <= in_v;
      if (in_v) begin
        y_q  <= y_lim;
        cb_q <= in_cb;
        cr_q <= in_cr;
      end
    end
  end

  assign out_v  = v_q;
  assign out_y  = y_q;
  assign out_cb = cb_q;
  assign out_cr = cr_q;

  generate
    if (CLAMP_EN) begin : g_floor_chk
      // R3
      luma_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_q |-> (y_q >= FLOOR_V));
    end
  endgenerate

  // R5
  pix_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && $past(v_q)) |=> !v_q);
endmodule

// File: rtl/p422_formatter.sv
module p422_formatter
  import p422_pkg::*;
#(
  parameter int W          = CW,
  parameter int FLOOR      = Y_FLOOR,
  parameter int SYNC_STAGE = 2
) (
  input  logic           clk2,
  input  logic           rst_n,
  input  logic           wide_mode,
  input  logic           blank_in,
  input  logic [2*W-1:0] pix_in,
  output logic           half_clk,
  output logic           valid_out,
  output logic [W-1:0]   y_out,
  output logic [W-1:0]   cb_out,
  output logic [W-1:0]   cr_out
);
  logic         rst_s_n;
  logic         half;
  logic         emit_v;
  logic [W-1:0] emit_y, emit_cb, emit_cr;

  p422_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk    (clk2),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  p422_half_gen u_half (
    .clk   (clk2),
    .rst_n (rst_s_n),
    .half  (half)
  );

  p422_unpack #(.W(W)) u_unpack (
    .clk     (clk2),
    .rst_n   (rst_s_n),
    .wide    (wide_mode),
    .half    (half),
    .blank   (blank_in),
    .pix     (pix_in),
    .emit_v  (emit_v),
    .emit_y  (emit_y),
    .emit_cb (emit_cb),
    .emit_cr (emit_cr)
  );

  p422_outreg #(.W(W), .FLOOR(FLOOR), .CLAMP_EN(1'b1)) u_out (
    .clk    (clk2),
    .rst_n  (rst_s_n),
    .in_v   (emit_v),
    .in_y   (emit_y),
    .in_cb  (emit_cb),
    .in_cr  (emit_cr),
    .out_v  (valid_out),
    .out_y  (y_out),
    .out_cb (cb_out),
    .out_cr (cr_out)
  );

  assign half_clk = half;
endmodule

// File: tb/p422_formatter_bench.sv
`timescale 1ns/1ps
module p422_formatter_bench;
  logic        clk2 = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic        blank_in = 1'b1;
  logic [15:0] pix_in = '0;
  logic        half_clk, valid_out;
  logic [7:0]  y_out, cb_out, cr_out;

  int total = 0;
  int bad   = 0;

  always #10 clk2 = ~clk2;

  p422_formatter u_p422_formatter (
    .clk2(clk2), .rst_n(rst_n), .wide_mode(wide_mode), .blank_in(blank_in),
    .pix_in(pix_in), .half_clk(half_clk), .valid_out(valid_out),
    .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out)
  );

  function automatic logic [7:0] lim(input logic [7:0] v);
    lim = (v < 8'd16) ? 8'd16 : v;
  endfunction

  task automatic tick(input logic [15:0] p, input logic b);
    @(negedge clk2);
    pix_in   = p;
    blank_in = b;
    @(posedge clk2);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic exp_pix(input string req, input logic [7:0] y,
                         input logic [7:0] cb, input logic [7:0] cr);
    check(req, {7'd0, valid_out, y_out, cb_out, cr_out}, {8'h01, y, cb, cr});
  endtask

  task automatic exp_idle(input string req);
    check(req, {31'd0, valid_out}, 32'd0);
  endtask

  task automatic align16;
    if (half_clk) tick(16'h0000, 1'b1);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic prev;
    // R1: reset values
    #35;
    check("R1", {7'd0, half_clk, valid_out, y_out, cb_out, cr_out}, 32'd0);
    @(negedge clk2);
    rst_n = 1'b1;
    repeat (3) tick(16'h0000, 1'b1);

    // R2: half-rate toggle
    for (int i = 0; i < 8; i++) begin
      prev = half_clk;
      tick(16'h0000, 1'b1);
      check("R2", {31'd0, half_clk}, {31'd0, ~prev});
    end

    // R3 R4 R5: narrow mode, all luma values, junk in low byte
    wide_mode = 1'b0;
    tick(16'h0000, 1'b1);
    for (int k = 0; k < 256; k++) begin
      logic [7:0] cb, cr, ya, yb;
      cb = 8'(k) ^ 8'h3C;
      cr = 8'(k + 77);
      ya = 8'(k);
      yb = 8'(255 - k);
      tick({cb, ~ya}, 1'b0);   exp_idle("R5");
      tick({ya, 8'h5A}, 1'b0); exp_idle("R5");
      tick({cr, ya}, 1'b0);    exp_pix("R3", lim(ya), cb, cr);
      tick({yb, cb}, 1'b0);    exp_pix("R4", lim(yb), cb, cr);
      if (k % 16 == 15) begin
        tick(16'hFFFF, 1'b1); exp_idle("R8");
        tick(16'hFFFF, 1'b1); exp_idle("R8");
      end
    end

    // R8: narrow line stopping mid-group
    tick({8'h11, 8'h00}, 1'b0);
    tick({8'h22, 8'h00}, 1'b0);
    tick(16'h0000, 1'b1); exp_idle("R8");
    tick(16'h0000, 1'b1); exp_idle("R8");
    tick({8'h40, 8'h00}, 1'b0); exp_idle("R8");
    tick({8'h50, 8'h00}, 1'b0); exp_idle("R8");
    tick({8'h60, 8'h00}, 1'b0); exp_pix("R8", 8'h50, 8'h40, 8'h60);
    tick({8'h05, 8'h00}, 1'b0); exp_pix("R8", 8'h10, 8'h40, 8'h60);
    tick(16'h0000, 1'b1);

    // R6 R7 R3: wide mode, junk and blank on off-phase edges
    wide_mode = 1'b1;
    tick(16'h0000, 1'b1);
    align16;
    tick(16'h0000, 1'b1);
    tick(16'h0000, 1'b1);
    for (int k = 0; k < 128; k++) begin
      logic [7:0] cb, cr, ya, yb;
      ya = 8'(2 * k);
      yb = 8'(2 * k + 1);
      cb = 8'(k) ^ 8'hA5;
      cr = 8'(255 - k);
      tick({ya, cb}, 1'b0);    exp_idle("R6");
      tick(16'hC33C, 1'b1);    exp_idle("R7");
      tick({yb, cr}, 1'b0);    exp_pix("R6", lim(ya), cb, cr);
      tick(16'h0FF0, 1'b1);    exp_pix("R7", lim(yb), cb, cr);
      if (k % 16 == 15) begin
        tick(16'hFFFF, 1'b1); exp_idle("R8");
        tick(16'hFFFF, 1'b0); exp_idle("R7");
      end
    end

    // R8: wide line stopping after one word
    tick({8'h30, 8'h70}, 1'b0);
    tick(16'h0000, 1'b0);
    tick(16'h0000, 1'b1); exp_idle("R8");
    tick(16'h0000, 1'b1); exp_idle("R8");
    tick({8'h80, 8'h90}, 1'b0); exp_idle("R8");
    tick(16'h0000, 1'b0);        exp_idle("R8");
    tick({8'h08, 8'h20}, 1'b0); exp_pix("R8", 8'h80, 8'h90, 8'h20);
    tick(16'h0000, 1'b0);        exp_pix("R8", 8'h10, 8'h90, 8'h20);
    tick(16'h0000, 1'b1);        exp_idle("R8");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule